// File: doc/BRIEF.md
# Digital Video Timing-Code Receiver

This block takes a component digital video byte stream, one element per cycle of its own pixel clock. In that stream the timing reference codes are embedded in the data. The block finds each four-word timing code and decodes the field, vertical-blanking and horizontal flags from its status word. It then passes downstream only the samples that the selected capture mode wants. Elements are 8 or 10 bits wide, chosen by a parameter.

The forwarded stream is registered and carries a valid strobe, a start-of-line marker, a start-of-field marker and the current field bit. The block also checks the protection bits of every status word and keeps a sticky error flag. Until the first timing code after reset is seen, nothing is forwarded.

Top module: `vid656_rx`

## Requirements
- R1: After reset `out_valid`, `out_sol`, `out_sof` and `prot_err` are 0. In every mode, no element reaches the output until the first word of the first timing code after reset.
- R2: A timing code is the all-ones word followed by two all-zeros words and a status word. In 8-bit alignment the status word has bit 7 = 1, F at bit 6, V at bit 5 and H at bit 4. H = 1 marks end of active video and H = 0 marks start of active video. The decoded F, V and H apply to all four code words and to every later element until the next code.
- R3: With `mode_i` = 0 (active picture), only elements after a code with H = 0 and V = 0 are forwarded. The four code words are never forwarded.
- R4: With `mode_i` = 1 (blanking lines), every element is forwarded while V = 1. This covers the code words and the horizontal blanking samples. Nothing is forwarded while V = 0.
- R5: With `mode_i` = 2 (whole field), every element is forwarded unchanged, including the code words.
- R6: With `mode_i` = 3, nothing is forwarded.
- R7: The protection bits in status bits 3..0 must equal {V^H, F^H, F^V, F^V^H}. A mismatch sets `prot_err`, which stays 1 until reset. The flags of that code are still used.
- R8: `out_sol` is 1 on the first forwarded element at or after the first word of a code with H = 0. A code with H = 1 cancels a pending marker.
- R9: `out_sof` is 1 on the first forwarded element at or after the first code after reset, and on the first forwarded element after a code whose F differs from the previous one. `out_field` carries the F that applies to each forwarded element.
- R10: With DW = 10 the behaviour is the same. The all-ones word is 0x3FF, status bits sit two places higher (F bit 8, V bit 7, H bit 6, protection bits 5..2), and status bits 1..0 must be 0 or `prot_err` is set.
- R11: Forwarded elements keep their input order and value. Each appears at the output five clock cycles after it was driven on `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Capture mode: 0 active picture, 1 blanking lines, 2 whole field, 3 none |
| din | input | DW | Input element, one per clock |
| out_valid | output | 1 | Forwarded element strobe |
| out_data | output | DW | Forwarded element |
| out_sol | output | 1 | Start-of-line marker |
| out_sof | output | 1 | Start-of-field marker |
| out_field | output | 1 | Field bit of the forwarded element |
| prot_err | output | 1 | Sticky protection-bit error |

## Verification
The same short sequence of lines is played in each of the four modes. It starts with samples before any code, then has blanking lines, picture lines, and a field change. Comparing what each mode forwards separates control-word removal, horizontal blanking, vertical blanking and the pre-lock gate. A run with a corrupted status word shows that the error flag is sticky while the decoded flags still steer the filter. Running a 10-bit instance in parallel on the same stimulus checks that the wider alignment decodes identically.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

   typedef enum logic [1:0] {
      VSR_ACTIVE = 2'd0,
      VSR_VBI    = 2'd1,
      VSR_FIELD  = 2'd2,
      VSR_NONE   = 2'd3
   } vsr_mode_e;

   localparam int VSR_CODE_LEN = 4;

   function automatic logic [3:0] vsr_prot(input logic f, input logic v, input logic h);
      return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

endpackage

// File: rtl/vsr_delay.sv
module vsr_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [W-1:0]              d_i,
   output logic [DEPTH-1:0][W-1:0]   tap_o
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("vsr_delay: DEPTH must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tap_o[gi] <= '0;
            end else if (gi == 0) begin
               tap_o[gi] <= d_i;
            end else begin
               tap_o[gi] <= tap_o[(gi == 0) ? 0 : gi-1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vsr_trs_decode.sv
module vsr_trs_decode
   import vsr_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] w_new,
   input  logic [DW-1:0] w_mid,
   input  logic [DW-1:0] w_old1,
   input  logic [DW-1:0] w_old,
   output logic          trs_o,
   output logic          lock_o,
   output logic          f_o,
   output logic          v_o,
   output logic          h_o,
   output logic          ctrl_o,
   output logic          fchg_o,
   output logic          err_o
);

   localparam int SH = DW - 8;
   localparam logic [DW-1:0] ALL1 = {DW{1'b1}};
   localparam int CW = $clog2(VSR_CODE_LEN);

   logic          locked_q, f_q, v_q, h_q;
   logic [CW-1:0] ctrl_cnt;
   logic          f_new, v_new, h_new, msb_ok, lsb_bad, bad;
   logic [3:0]    p_rx;

   assign trs_o  = (w_old == ALL1) && (w_old1 == '0) && (w_mid == '0);
   assign f_new  = w_new[6+SH];
   assign v_new  = w_new[5+SH];
   assign h_new  = w_new[4+SH];
   assign p_rx   = w_new[3+SH:SH];
   assign msb_ok = w_new[DW-1];

   generate
      if (SH > 0) begin : g_wide
         assign lsb_bad = |w_new[(SH > 0 ? SH-1 : 0):0];
      end else begin : g_narrow
         assign lsb_bad = 1'b0;
      end
   endgenerate

   assign bad = trs_o && ((p_rx != vsr_prot(f_new, v_new, h_new)) || !msb_ok || lsb_bad);

   assign lock_o = trs_o | locked_q;
   assign f_o    = trs_o ? f_new : f_q;
   assign v_o    = trs_o ? v_new : v_q;
   assign h_o    = trs_o ? h_new : h_q;
   assign ctrl_o = trs_o | (ctrl_cnt != '0);
   assign fchg_o = trs_o && (!locked_q || (f_new != f_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         f_q      <= 1'b0;
         v_q      <= 1'b0;
         h_q      <= 1'b0;
         ctrl_cnt <= '0;
         err_o    <= 1'b0;
      end else begin
         if (trs_o) begin
            locked_q <= 1'b1;
            f_q      <= f_new;
            v_q      <= v_new;
            h_q      <= h_new;
            ctrl_cnt <= CW'(VSR_CODE_LEN - 1);
         end else if (ctrl_cnt != '0) begin
            ctrl_cnt <= ctrl_cnt - 1'b1;
         end
         if (bad) begin
            err_o <= 1'b1;
         end
      end
   end

   AST_TRS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      trs_o |=> lock_o);                                                  // R2
   AST_CODE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      trs_o |=> ctrl_o);                                                  // R3
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);                                                   // R7

endmodule

// File: rtl/vsr_gate.sv
module vsr_gate
   import vsr_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_i,
   input  logic [DW-1:0] word_i,
   input  logic          trs_i,
   input  logic          lock_i,
   input  logic          f_i,
   input  logic          v_i,
   input  logic          h_i,
   input  logic          ctrl_i,
   input  logic          fchg_i,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_sol,
   output logic          out_sof,
   output logic          out_field
);

   vsr_mode_e mode;
   logic      pass, sol_q, sof_q, sol_eff, sof_eff;

   assign mode = vsr_mode_e'(mode_i);

   always_comb begin
      pass = 1'b0;
      if (lock_i) begin
         unique case (mode)
            VSR_ACTIVE: pass = !ctrl_i && !v_i && !h_i;
            VSR_VBI:    pass = v_i;
            VSR_FIELD:  pass = 1'b1;
            VSR_NONE:   pass = 1'b0;
            default:    pass = 1'b0;
         endcase
      end
   end

   assign sol_eff = trs_i ? !h_i : sol_q;
   assign sof_eff = fchg_i | sof_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sol_q     <= 1'b0;
         sof_q     <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sol   <= 1'b0;
         out_sof   <= 1'b0;
         out_field <= 1'b0;
      end else begin
         sol_q     <= pass ? 1'b0 : sol_eff;
         sof_q     <= pass ? 1'b0 : sof_eff;
         out_valid <= pass;
         out_sol   <= pass && sol_eff;
         out_sof   <= pass && sof_eff;
         if (pass) begin
            out_data  <= word_i;
            out_field <= f_i;
         end
      end
   end

   AST_NO_PASS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_i |=> !out_valid);                                            // R1
   AST_ACTIVE_DROPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == VSR_ACTIVE && ctrl_i) |=> !out_valid);                     // R3
   AST_VBI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == VSR_VBI && !v_i) |=> !out_valid);                          // R4
   AST_FIELD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == VSR_FIELD && lock_i) |=> out_valid);                       // R5
   AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == VSR_NONE) |=> !out_valid);                                 // R6
   AST_SOL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_sol |=> !out_sol);                                              // R8

endmodule

// File: rtl/vid656_rx.sv
module vid656_rx
   import vsr_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_i,
   input  logic [DW-1:0] din,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_sol,
   output logic          out_sof,
   output logic          out_field,
   output logic          prot_err
);

   generate
      if (DW != 8 && DW != 10) begin : g_bad_dw
         $error("vid656_rx: DW must be 8 or 10");
      end
   endgenerate

   logic [VSR_CODE_LEN-1:0][DW-1:0] taps;
   logic trs, lock, fl, vb, hb, ctrl, fchg;

   vsr_delay #(.W(DW), .DEPTH(VSR_CODE_LEN)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (din),
      .tap_o (taps)
   );

   vsr_trs_decode #(.DW(DW)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .w_new  (taps[0]),
      .w_mid  (taps[1]),
      .w_old1 (taps[2]),
      .w_old  (taps[3]),
      .trs_o  (trs),
      .lock_o (lock),
      .f_o    (fl),
      .v_o    (vb),
      .h_o    (hb),
      .ctrl_o (ctrl),
      .fchg_o (fchg),
      .err_o  (prot_err)
   );

   vsr_gate #(.DW(DW)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode_i),
      .word_i    (taps[VSR_CODE_LEN-1]),
      .trs_i     (trs),
      .lock_i    (lock),
      .f_i       (fl),
      .v_i       (vb),
      .h_i       (hb),
      .ctrl_i    (ctrl),
      .fchg_i    (fchg),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_sol   (out_sol),
      .out_sof   (out_sof),
      .out_field (out_field)
   );

endmodule

// File: tb/vid656_rx_test.sv
`timescale 1ns/1ps
module vid656_rx_test;

   typedef struct {
      logic [7:0] d;
      logic       sol;
      logic       sof;
      logic       fld;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [7:0] din8 = 8'h80;
   logic [9:0] din10;

   logic       v8, sol8, sof8, f8, e8;
   logic [7:0] d8;
   logic       v10, sol10, sof10, f10, e10;
   logic [9:0] d10;

   int errors = 0;
   int checks = 0;
   int seen   = 0;
   int seed   = 0;
   string tag = "R1";

   exp_t q8[$];
   exp_t q10[$];

   logic m_lock, m_sol, m_sof, m_f, m_v, m_h;

   always #2 clk = ~clk;

   function automatic logic [9:0] widen(input logic [7:0] w);
      return (w == 8'hFF) ? 10'h3FF : {w, 2'b00};
   endfunction

   assign din10 = widen(din8);

   vid656_rx #(.DW(8)) uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .din(din8),
      .out_valid(v8), .out_data(d8), .out_sol(sol8), .out_sof(sof8),
      .out_field(f8), .prot_err(e8));

   vid656_rx #(.DW(10)) uut10 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .din(din10),
      .out_valid(v10), .out_data(d10), .out_sol(sol10), .out_sof(sof10),
      .out_field(f10), .prot_err(e10));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Monitor 8-bit instance; R11 order and value through the scoreboard
   always @(negedge clk) begin
      if (rst_n && v8) begin
         seen++;
         if (q8.size() == 0) begin
            check(1'b0, tag, "unexpected element (8b)", d8, 0);
         end else begin
            exp_t e;
            e = q8.pop_front();
            check(d8 == e.d, tag, "R11 data (8b)", d8, e.d);
            check(sol8 == e.sol, "R8", "sol (8b)", sol8, e.sol);
            check(sof8 == e.sof && f8 == e.fld, "R9", "sof/field (8b)",
                  {sof8, f8}, {e.sof, e.fld});
         end
      end
   end

   // Monitor 10-bit instance (R10)
   always @(negedge clk) begin
      if (rst_n && v10) begin
         if (q10.size() == 0) begin
            check(1'b0, "R10", "unexpected element (10b)", d10, 0);
         end else begin
            exp_t e;
            e = q10.pop_front();
            check(d10 == widen(e.d), "R10", "data (10b)", d10, widen(e.d));
            check(sol10 == e.sol && sof10 == e.sof && f10 == e.fld, "R10",
                  "markers (10b)", {sol10, sof10, f10}, {e.sol, e.sof, e.fld});
         end
      end
   end

   task automatic drive(input logic [7:0] w);
      din8 = w;
      @(negedge clk);
   endtask

   task automatic push(input logic [7:0] w, input bit pass);
      if (pass) begin
         exp_t e;
         e.d = w; e.sol = m_sol; e.sof = m_sof; e.fld = m_f;
         m_sol = 1'b0; m_sof = 1'b0;
         q8.push_back(e);
         q10.push_back(e);
      end
      drive(w);
   endtask

   task automatic send_trs(input logic f, input logic v, input logic h, input bit corrupt);
      logic [7:0] xy;
      bit pass;
      xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
      if (corrupt) xy[0] = ~xy[0];
      if (!m_lock || f != m_f) m_sof = 1'b1;
      m_lock = 1'b1; m_sol = !h; m_f = f; m_v = v; m_h = h;
      pass = (mode == 2'd2) || (mode == 2'd1 && v);
      push(8'hFF, pass);
      push(8'h00, pass);
      push(8'h00, pass);
      push(xy, pass);
   endtask

   task automatic send_data(input int n, input logic [7:0] fixed = 8'h00);
      for (int k = 0; k < n; k++) begin
         logic [7:0] w;
         bit pass;
         w = (fixed != 8'h00) ? fixed : 8'h10 + 8'(seed % 64);
         seed++;
         pass = m_lock && ((mode == 2'd2) || (mode == 2'd1 && m_v) ||
                           (mode == 2'd0 && !m_v && !m_h));
         push(w, pass);
      end
   endtask

   task automatic send_line(input logic f, input logic v, input int nb, input int na);
      send_trs(f, v, 1'b1, 1'b0);
      send_data(nb);
      send_trs(f, v, 1'b0, 1'b0);
      send_data(na);
   endtask

   task automatic start(input logic [1:0] md, input string t);
      rst_n = 1'b0;
      din8  = 8'h80;
      mode  = md;
      tag   = t;
      repeat (3) @(negedge clk);
      q8.delete(); q10.delete();
      m_lock = 0; m_sol = 0; m_sof = 0; m_f = 0; m_v = 0; m_h = 0;
      seen = 0;
      check(!v8 && !sol8 && !sof8 && !e8 && !v10 && !e10, "R1", "reset outputs",
            {v8, sol8, sof8, e8, v10, e10}, 0);
      rst_n = 1'b1;
   endtask

   // Push filler through the pipe; leftovers must all be filler
   task automatic finish_run();
      bit ok;
      send_data(6, 8'h80);
      ok = 1'b1;
      foreach (q8[i]) if (q8[i].d != 8'h80) ok = 1'b0;
      foreach (q10[i]) if (q10[i].d != 8'h80) ok = 1'b0;
      check(ok, tag, "expected elements never forwarded", q8.size(), 0);
   endtask

   task automatic frame();
      send_data(5);                 // before any code: R1
      send_line(1'b0, 1'b1, 4, 5);  // blanking line
      send_line(1'b0, 1'b0, 4, 6);  // picture line
      send_line(1'b0, 1'b0, 3, 5);
      send_line(1'b1, 1'b0, 3, 5);  // field change, R9
      send_line(1'b1, 1'b1, 3, 4);  // back to blanking
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);

      // R3 active picture only
      start(2'd0, "R3");
      frame();
      finish_run();

      // R4 blanking lines only
      start(2'd1, "R4");
      frame();
      finish_run();

      // R5 whole field, R2 decode via markers
      start(2'd2, "R5");
      frame();
      finish_run();
      check(!e8 && !e10, "R7", "no error on clean stream", e8, 0);

      // R6 nothing forwarded
      start(2'd3, "R6");
      frame();
      finish_run();
      check(seen == 0, "R6", "elements seen in mode 3", seen, 0);

      // R7 corrupt status word: sticky error, flags still used
      start(2'd0, "R7");
      send_line(1'b0, 1'b0, 3, 4);
      send_data(6);
      check(!e8 && !e10, "R7", "error before corruption", {e8, e10}, 0);
      send_trs(1'b0, 1'b1, 1'b1, 1'b1);
      send_data(3);
      send_trs(1'b0, 1'b0, 1'b0, 1'b1);  // corrupted code still opens the line
      send_data(5);
      check(e8 && e10, "R7", "error after corruption", {e8, e10}, 2'b11);
      send_line(1'b0, 1'b0, 3, 4);
      finish_run();
      check(e8 && e10, "R7", "error stays set", {e8, e10}, 2'b11);

      // R11 latency: first element of a code appears five cycles later
      start(2'd2, "R11");
      din8 = 8'hFF; @(negedge clk);
      din8 = 8'h00; @(negedge clk);
      @(negedge clk);
      din8 = 8'h80; @(negedge clk);
      check(!v8, "R11", "valid before latency", v8, 0);
      @(negedge clk);
      check(v8 && d8 == 8'hFF, "R11", "code word at fifth cycle", d8, 8'hFF);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      q8.delete(); q10.delete();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule